// File: doc/BRIEF.md
# Serial ADC Frame Classifier

This block listens, without driving anything, to the chip-select, serial clock and data lines between a host and a 12-bit serial converter. Each window in which chip-select is low is one frame. During the frame the block counts rising serial-clock edges and shifts the data line in on each of them, most significant bit first. When chip-select goes high again, the block decides what the frame meant. A very short frame is a power-down request. A frame of ordinary length that reads back all ones is a wake-up (dummy) frame. Any other frame is a normal conversion, and the block tags that conversion as complete or cut short.

All three bus lines pass through a two-flop synchroniser into the system clock domain, where edges are detected. The verdict is announced by a one-cycle `frame_valid` pulse. The mode, flags and 12-bit code stay on their pins until the next frame ends. The block watches a bus and cannot stall it, so the result interface has no ready input and there is no back-pressure. A consumer that needs the result must accept it in the pulse cycle, or read the held outputs before the next chip-select rising edge is processed.

Top module: `adc_frame_monitor`

## Requirements
- R1: A frame opens on a falling edge of `cs_n_pin` and closes on its rising edge. Results update only when a frame closes. `frame_valid` is high for exactly one `clk` cycle, in the cycle after the third `clk` rising edge that follows the pin's rise.
- R2: A frame with fewer than 10 serial-clock rising edges reports `mode` = 1 (power-down), `invalid` = 1, `complete` = 0 and `overlength` = 0.
- R3: A frame with 10 or more edges whose captured 12-bit code is 0xFFF reports `mode` = 2 (power-up), `invalid` = 1, `complete` = 0 and `overlength` = 0.
- R4: Any other frame with 10 or more edges reports `mode` = 0 (normal) with `invalid` = 0.
- R5: `complete` is 1 only for a normal frame of exactly 16 edges. A normal frame of 10 to 15 edges reports `complete` = 0.
- R6: `sdo_pin` is sampled on each serial-clock rising edge, most significant bit first. `code` holds the last 12 bits sampled, with the latest bit in bit 0. Leading bits beyond 12 are discarded, and bits never sampled read as 0. This holds in every mode.
- R7: The edge counter saturates at 31. A normal frame of more than 16 edges, including one far longer than 31, reports `overlength` = 1 and `complete` = 0.
- R8: The counter and the shift register are cleared when a frame closes, so a frame never carries bits over from the one before.
- R9: Serial-clock edges while chip-select is high are neither counted nor shifted. All result outputs hold their values between frame closings.
- R10: A synchronous active-high `rst` clears every output to 0 and treats chip-select as high. A chip-select pin that is already high when reset is released produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n_pin | input | 1 | Monitored chip-select, active low, asynchronous |
| sclk_pin | input | 1 | Monitored serial clock, asynchronous |
| sdo_pin | input | 1 | Monitored converter data output, asynchronous |
| frame_valid | output | 1 | One-cycle pulse when a frame has been classified |
| mode | output | 2 | 0 normal, 1 power-down, 2 power-up |
| complete | output | 1 | Normal frame with exactly 16 edges |
| invalid | output | 1 | Code is not a conversion result |
| overlength | output | 1 | Normal frame with more than 16 edges |
| code | output | 12 | Last 12 bits captured in the frame |

## Verification
The main function is driven with frames of 0, 9, 10, 12, 15, 16, 17, 20 and 40 serial-clock edges. Together these pin down each edge-count boundary: power-down against normal, incomplete against complete, complete against over-length, and the saturating counter. Codes of all ones are sent at 12, 16 and 17 edges to show that the wake-up pattern takes priority over the length verdict. A 10-edge frame of 0x3FF shows that a near-miss is not taken for the wake-up pattern. Frames whose leading bits differ from their last 12 show that only the trailing bits count. A short frame of zeros sent straight after an all-ones frame shows that no state survives from one frame to the next. Serial-clock toggling with chip-select high, and a reset with the pin already high, show that neither starts or alters a frame.

// File: rtl/adcmon_pkg.sv
package adcmon_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PWRDN  = 2'd1,
    MODE_PWRUP  = 2'd2
  } adc_mode_e;

  localparam int LINE_CS   = 0;
  localparam int LINE_SCLK = 1;
  localparam int LINE_SDO  = 2;
  localparam int NUM_LINES = 3;
endpackage

// File: rtl/adcmon_sync.sv
module adcmon_sync #(
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_line
      logic meta_q;
      logic safe_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= RST_VAL[i];
          safe_q <= RST_VAL[i];
        end else begin
          meta_q <= d_in[i];
          safe_q <= meta_q;
        end
      end
      assign q_out[i] = safe_q;
    end
  endgenerate
endmodule

// File: rtl/adcmon_capture.sv
module adcmon_capture #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdo,
  output logic              frame_end,
  output logic [CNT_W-1:0]  edge_cnt,
  output logic [DATA_W-1:0] shreg
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic cs_prev;
  logic sclk_prev;
  logic cs_fall;
  logic sclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_n;
      sclk_prev <= sclk;
    end
  end

  assign frame_end = cs_n & ~cs_prev;
  assign cs_fall   = ~cs_n & cs_prev;
  assign sclk_rise = sclk & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst || frame_end || cs_fall) begin
      edge_cnt <= '0;
      shreg    <= '0;
    end else if (!cs_n && sclk_rise) begin
      if (edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
      shreg <= {shreg[DATA_W-2:0], sdo};
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !cs_fall && sclk_rise && edge_cnt == CNT_MAX) |=> edge_cnt == CNT_MAX); // R7
  AST_CLEARED_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (edge_cnt == '0 && shreg == '0)); // R8
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !frame_end) |=> ($stable(edge_cnt) && $stable(shreg))); // R9
endmodule

// File: rtl/adcmon_classify.sv
module adcmon_classify
  import adcmon_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CNT_W     = 5,
  parameter int MIN_CLKS  = 10,
  parameter int FULL_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  edge_cnt,
  input  logic [DATA_W-1:0] shreg,
  output logic              frame_valid,
  output adc_mode_e         mode,
  output logic              complete,
  output logic              invalid,
  output logic              overlength,
  output logic [DATA_W-1:0] code
);
  localparam logic [CNT_W-1:0]  MIN_C   = CNT_W'(MIN_CLKS);
  localparam logic [CNT_W-1:0]  FULL_C  = CNT_W'(FULL_CLKS);
  localparam logic [DATA_W-1:0] ALL_ONE = {DATA_W{1'b1}};

  logic short_f;
  logic wake_f;

  assign short_f = edge_cnt < MIN_C;
  assign wake_f  = !short_f && (shreg == ALL_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      mode        <= MODE_NORMAL;
      complete    <= 1'b0;
      invalid     <= 1'b0;
      overlength  <= 1'b0;
      code        <= '0;
    end else begin
      frame_valid <= frame_end;
      if (frame_end) begin
        code <= shreg;
        if (short_f) begin
          mode       <= MODE_PWRDN;
          invalid    <= 1'b1;
          complete   <= 1'b0;
          overlength <= 1'b0;
        end else if (wake_f) begin
          mode       <= MODE_PWRUP;
          invalid    <= 1'b1;
          complete   <= 1'b0;
          overlength <= 1'b0;
        end else begin
          mode       <= MODE_NORMAL;
          invalid    <= 1'b0;
          complete   <= (edge_cnt == FULL_C);
          overlength <= (edge_cnt > FULL_C);
        end
      end
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid); // R1
  AST_SHORT_IS_PWRDN: assert property (@(posedge clk) disable iff (rst)
    (frame_end && edge_cnt < MIN_C) |=> (frame_valid && mode == MODE_PWRDN && invalid)); // R2
  AST_ONES_IS_PWRUP: assert property (@(posedge clk) disable iff (rst)
    (frame_end && edge_cnt >= MIN_C && shreg == ALL_ONE) |=> (mode == MODE_PWRUP && invalid)); // R3
  AST_COMPLETE_NORMAL: assert property (@(posedge clk) disable iff (rst)
    complete |-> (mode == MODE_NORMAL && !invalid && !overlength)); // R5
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(code) && $stable(mode) && $stable(complete) && $stable(invalid))); // R9
endmodule

// File: rtl/adc_frame_monitor.sv
module adc_frame_monitor
  import adcmon_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CNT_W     = 5,
  parameter int MIN_CLKS  = 10,
  parameter int FULL_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_pin,
  input  logic              sclk_pin,
  input  logic              sdo_pin,
  output logic              frame_valid,
  output logic [1:0]        mode,
  output logic              complete,
  output logic              invalid,
  output logic              overlength,
  output logic [DATA_W-1:0] code
);
  localparam logic [NUM_LINES-1:0] SYNC_RST = NUM_LINES'(1) << LINE_CS;

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] sync_lines;
  logic                 frame_end;
  logic [CNT_W-1:0]     edge_cnt;
  logic [DATA_W-1:0]    shreg;
  adc_mode_e            mode_e;

  always_comb begin
    raw_lines            = '0;
    raw_lines[LINE_CS]   = cs_n_pin;
    raw_lines[LINE_SCLK] = sclk_pin;
    raw_lines[LINE_SDO]  = sdo_pin;
  end

  adcmon_sync #(.W(NUM_LINES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_lines), .q_out(sync_lines)
  );

  adcmon_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst(rst),
    .cs_n(sync_lines[LINE_CS]), .sclk(sync_lines[LINE_SCLK]), .sdo(sync_lines[LINE_SDO]),
    .frame_end(frame_end), .edge_cnt(edge_cnt), .shreg(shreg)
  );

  adcmon_classify #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_CLKS(MIN_CLKS), .FULL_CLKS(FULL_CLKS)
  ) u_classify (
    .clk(clk), .rst(rst), .frame_end(frame_end), .edge_cnt(edge_cnt), .shreg(shreg),
    .frame_valid(frame_valid), .mode(mode_e), .complete(complete),
    .invalid(invalid), .overlength(overlength), .code(code)
  );

  assign mode = mode_e;

  AST_NO_PULSE_WHILE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cs_n_pin && $stable(cs_n_pin) && frame_valid) |-> !$past(frame_valid)); // R10
endmodule

// File: tb/sim_adc_frame_monitor.sv
module sim_adc_frame_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n_pin = 1'b1;
  logic        sclk_pin = 1'b0;
  logic        sdo_pin = 1'b0;
  logic        frame_valid;
  logic [1:0]  mode;
  logic        complete;
  logic        invalid;
  logic        overlength;
  logic [11:0] code;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_frame_monitor u0 (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin), .sdo_pin(sdo_pin),
    .frame_valid(frame_valid), .mode(mode), .complete(complete),
    .invalid(invalid), .overlength(overlength), .code(code)
  );

  typedef struct packed {
    logic [6:0]  nclk;
    logic [63:0] pat;
    logic [1:0]  emode;
    logic        ecmp;
    logic        einv;
    logic        eovr;
    logic [11:0] ecode;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{7'd16, 64'h0ABC,  2'd0, 1'b1, 1'b0, 1'b0, 12'hABC},
    '{7'd16, 64'hF123,  2'd0, 1'b1, 1'b0, 1'b0, 12'h123},
    '{7'd12, 64'h5A5,   2'd0, 1'b0, 1'b0, 1'b0, 12'h5A5},
    '{7'd10, 64'h3FF,   2'd0, 1'b0, 1'b0, 1'b0, 12'h3FF},
    '{7'd15, 64'h7ABC,  2'd0, 1'b0, 1'b0, 1'b0, 12'hABC},
    '{7'd9,  64'h1FF,   2'd1, 1'b0, 1'b1, 1'b0, 12'h1FF},
    '{7'd0,  64'h0,     2'd1, 1'b0, 1'b1, 1'b0, 12'h000},
    '{7'd16, 64'hFFFF,  2'd2, 1'b0, 1'b1, 1'b0, 12'hFFF},
    '{7'd12, 64'hFFF,   2'd2, 1'b0, 1'b1, 1'b0, 12'hFFF},
    '{7'd20, 64'h12345, 2'd0, 1'b0, 1'b0, 1'b1, 12'h345},
    '{7'd40, 64'h777,   2'd0, 1'b0, 1'b0, 1'b1, 12'h777},
    '{7'd17, 64'h1FFFF, 2'd2, 1'b0, 1'b1, 1'b0, 12'hFFF},
    '{7'd10, 64'h000,   2'd0, 1'b0, 1'b0, 1'b0, 12'h000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdo_pin  = b;
    sclk_pin = 1'b0;
    wait_cyc(4);
    sclk_pin = 1'b1;
    wait_cyc(4);
  endtask

  task automatic send_frame(input int n, input logic [63:0] pat);
    @(negedge clk);
    cs_n_pin = 1'b0;
    wait_cyc(4);
    for (int i = n - 1; i >= 0; i--) send_bit(pat[i]);
    @(negedge clk);
    sclk_pin = 1'b0;
    wait_cyc(4);
    cs_n_pin = 1'b1;
  endtask

  task automatic expect_result(input vec_t v, input string tag);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(frame_valid == 1'b0, {"R1 early ", tag}, frame_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk(frame_valid == 1'b1, {"R1 pulse ", tag}, frame_valid, 1);
    chk(mode == v.emode, {"R2 R3 R4 mode ", tag}, mode, v.emode);
    chk(invalid == v.einv, {"R2 R3 R4 invalid ", tag}, invalid, v.einv);
    chk(complete == v.ecmp, {"R5 complete ", tag}, complete, v.ecmp);
    chk(overlength == v.eovr, {"R7 overlength ", tag}, overlength, v.eovr);
    chk(code == v.ecode, {"R6 R8 code ", tag}, code, v.ecode);
    @(negedge clk);
    chk(frame_valid == 1'b0, {"R1 width ", tag}, frame_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    vec_t hold;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    // R10: reset state
    chk({frame_valid, mode, complete, invalid, overlength, code} == '0, "R10 reset outputs",
        {frame_valid, mode, complete, invalid, overlength, code}, 0);

    for (int k = 0; k < NV; k++) begin
      send_frame(VEC[k].nclk, VEC[k].pat);
      expect_result(VEC[k], $sformatf("vec%0d", k));
    end

    // R9: serial clock toggling with chip-select high changes nothing
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    @(negedge clk);
    sclk_pin = 1'b0;
    wait_cyc(6);
    chk(frame_valid == 1'b0, "R9 no pulse while idle", frame_valid, 0);
    chk(code == 12'h000 && mode == 2'd0, "R9 outputs held", {mode, code}, 0);
    hold = '{7'd12, 64'h0F0, 2'd0, 1'b0, 1'b0, 1'b0, 12'h0F0};
    send_frame(12, 64'h0F0);
    expect_result(hold, "idle-clk");

    // R9: outputs held while a later frame is in progress
    @(negedge clk);
    cs_n_pin = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    chk(code == 12'h0F0 && frame_valid == 1'b0, "R9 held mid-frame", code, 12'h0F0);

    // R10: reset mid-frame, pin high at release, no frame reported
    @(negedge clk);
    rst = 1'b1;
    cs_n_pin = 1'b1;
    sclk_pin = 1'b0;
    wait_cyc(3);
    rst = 1'b0;
    begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (frame_valid) seen = 1'b1;
      end
      chk(!seen, "R10 no frame after reset", seen, 0);
    end
    chk({mode, complete, invalid, overlength, code} == '0, "R10 cleared",
        {mode, complete, invalid, overlength, code}, 0);

    hold = '{7'd16, 64'hC00, 2'd0, 1'b1, 1'b0, 1'b0, 12'hC00};
    send_frame(16, 64'hC00);
    expect_result(hold, "post-reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule